// File: doc/BRIEF.md
# Sectored Super-Block Tag Lookup

This block is the tag lookup and classification stage of a sectored last-level cache. One tag entry covers a super-block of four neighbouring 64-byte lines, called sub-blocks. Each entry keeps one valid bit per sub-block. A request address is split into offset, sub-block, set and tag fields. Every way of the indexed set is compared against the tag, and the outcome is reported one cycle later as one of three kinds:

- super-block miss
- super-block hit with sub-block miss
- full hit

The block also updates its own tag, valid and recency state. On a super-block miss it picks a victim way: the lowest-numbered empty way if one exists, otherwise the least recently used of the set's ways. The whole victim entry is replaced at once. On a sub-block miss a compressibility input decides between two actions:

- co-allocate the new sub-block beside its siblings, or
- drop the siblings and keep only the new sub-block.

A sub-block miss inside a resident super-block is flagged as a prefetch-candidate event.

Data storage, decompression and refill from memory lie outside this block. Only tags, valid bits and recency state are held here.

Top module: `sb_lookup`

## Requirements
- R1: The address splits as follows. Bits [5:0] are the line offset and are ignored. Bits [7:6] give the sub-block index 0..3. The next log2(SETS) bits are the set index, and the remaining upper bits are the tag.
- R2: `req_ready` is high whenever reset is low. A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` pulses high exactly one cycle after each accepted request and is low in every other cycle.
- R3: All ways of the indexed set are compared. When no way holds a matching tag with at least one valid sub-block, `rsp_kind` is 1 (super-block miss).
- R4: When a way matches but the addressed sub-block's valid bit is clear, `rsp_kind` is 2 (sub-block miss) and `rsp_way` is the matching way.
- R5: `rsp_prefetch_cand` is high exactly when the response kind is 2.
- R6: When a way matches and the addressed sub-block is valid, `rsp_kind` is 3 (full hit) and `rsp_way` is the matching way.
- R7: On a super-block miss the victim is the lowest-numbered way with no valid sub-block. If every way holds data, the victim is the least recently used way. The victim is reported on both `rsp_victim` and `rsp_way`. The new tag is written with only the addressed sub-block valid, and all previous valid bits are cleared together. `rsp_victim` is 0 for kinds 2 and 3.
- R8: On a sub-block miss with `req_coalloc` = 1, the addressed sub-block becomes valid and its sibling sub-blocks remain valid.
- R9: On a sub-block miss with `req_coalloc` = 0, the sibling sub-blocks are invalidated and only the addressed sub-block is valid afterwards.
- R10: Every accepted request makes the way it hit or installed the most recently used way of its set. Recency is tracked over all 16 ways.
- R11: Sets are independent. An access to one set never changes the outcome of a later access to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_coalloc | input | 1 | Addressed sub-block can share its super-block's entry |
| rsp_valid | output | 1 | Response present (one cycle after accept) |
| rsp_kind | output | 2 | 1 super-block miss, 2 sub-block miss, 3 full hit |
| rsp_way | output | log2(WAYS) | Matching way, or installed way on a super-block miss |
| rsp_victim | output | log2(WAYS) | Victim way on a super-block miss, else 0 |
| rsp_prefetch_cand | output | 1 | Sub-block miss inside a resident super-block |

## Verification
The hardest situation to reach is replacement of a full set by recency order. It needs all 16 ways of one set filled with distinct tags before any choice is made by recency instead of by emptiness. The stimulus first builds up several sub-blocks in way 0 and then installs fifteen further tags. It then touches way 0 again so that way 1 becomes the oldest. A new tag must land in way 1 and leave only one valid sub-block. A second new tag must then land in way 2.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_SB_MISS  = 2'd1,
    KIND_SUB_MISS = 2'd2,
    KIND_HIT      = 2'd3
  } lookup_kind_e;
endpackage

// File: rtl/sbl_tag_store.sv
module sbl_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 16,
  parameter int TAG_W = 18,
  parameter int SUBS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  output logic [WAYS-1:0][SUBS-1:0]   rd_vbits,
  input  logic                        wr_en,
  input  logic                        wr_tag_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [SUBS-1:0]             wr_vbits
);
  logic [TAG_W-1:0] tag_mem  [SETS][WAYS];
  logic [SUBS-1:0]  vbit_mem [SETS][WAYS];

  // Tag array: no reset, so it can map onto plain storage.
  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) tag_mem[wr_set][wr_way] <= wr_tag;
  end

  // Valid bits: cleared by reset, whole vector written on each update.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vbit_mem[s][w] <= '0;
    end else if (wr_en) begin
      vbit_mem[wr_set][wr_way] <= wr_vbits;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags[w]  = tag_mem[rd_set][w];
    assign rd_vbits[w] = vbit_mem[rd_set][w];
  end

  // A freshly installed super-block holds exactly one valid sub-block.
  p_install_single_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tag_en) |=> ($countones(vbit_mem[$past(wr_set)][$past(wr_way)]) == 1));
endmodule

// File: rtl/sbl_match.sv
module sbl_match #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 18,
  parameter int SUBS  = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][SUBS-1:0]  vbits,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [SUB_W-1:0]           req_sub,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       sb_hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       sub_valid,
  output logic [SUBS-1:0]            hit_vbits,
  output logic                       empty_found,
  output logic [WAY_W-1:0]           empty_way
);
  logic [WAYS-1:0] empty_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign empty_vec[w] = (vbits[w] == '0);
    assign hit_vec[w]   = !empty_vec[w] && (tags[w] == req_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    empty_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (empty_vec[w]) empty_way = WAY_W'(w);
  end

  assign sb_hit      = |hit_vec;
  assign empty_found = |empty_vec;
  assign hit_vbits   = vbits[hit_way];
  assign sub_valid   = hit_vbits[req_sub];
endmodule

// File: rtl/sbl_lru.sv
module sbl_lru #(
  parameter int SETS = 64,
  parameter int WAYS = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] lru_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);
  // Each way holds its recency rank: 0 is newest, WAYS-1 is oldest.
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] upd_old;

  assign upd_old = age_q[upd_set][upd_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)            age_q[upd_set][w] <= '0;
        else if (age_q[upd_set][w] < upd_old) age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_set][w] == AGE_W'(WAYS - 1)) lru_way = WAY_W'(w);
  end

  // The way touched by an access is the newest of its set afterwards.
  p_mru_after_touch_r10: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (age_q[$past(upd_set)][$past(upd_way)] == '0));
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
  import sbl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SUBS       = 4,
  parameter int SETS       = 64,
  parameter int WAYS       = 16,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SUB_W = $clog2(SUBS),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SUB_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_coalloc,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WAY_W-1:0]  rsp_victim,
  output logic              rsp_prefetch_cand
);
  logic [SUB_W-1:0] f_sub;
  logic [SET_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;

  assign f_sub = req_addr[OFF_W +: SUB_W];
  assign f_set = req_addr[OFF_W + SUB_W +: SET_W];
  assign f_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic accept;
  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  logic [WAYS-1:0][TAG_W-1:0] rd_tags;
  logic [WAYS-1:0][SUBS-1:0]  rd_vbits;
  logic [WAYS-1:0]            hit_vec;
  logic                       sb_hit, sub_valid, empty_found;
  logic [WAY_W-1:0]           hit_way, empty_way, lru_way;
  logic [SUBS-1:0]            hit_vbits;

  lookup_kind_e     kind_c;
  logic [WAY_W-1:0] target_way;
  logic             wr_en, wr_tag_en;
  logic [SUBS-1:0]  new_vbits, sub_onehot;

  sbl_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SUBS(SUBS)) u_store (
    .clk(clk), .rst(rst), .rd_set(f_set), .rd_tags(rd_tags), .rd_vbits(rd_vbits),
    .wr_en(wr_en), .wr_tag_en(wr_tag_en), .wr_set(f_set), .wr_way(target_way),
    .wr_tag(f_tag), .wr_vbits(new_vbits)
  );

  sbl_match #(.WAYS(WAYS), .TAG_W(TAG_W), .SUBS(SUBS)) u_match (
    .tags(rd_tags), .vbits(rd_vbits), .req_tag(f_tag), .req_sub(f_sub),
    .hit_vec(hit_vec), .sb_hit(sb_hit), .hit_way(hit_way), .sub_valid(sub_valid),
    .hit_vbits(hit_vbits), .empty_found(empty_found), .empty_way(empty_way)
  );

  sbl_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst(rst), .rd_set(f_set), .lru_way(lru_way),
    .upd_en(accept), .upd_set(f_set), .upd_way(target_way)
  );

  assign sub_onehot = SUBS'(1) << f_sub;

  always_comb begin
    kind_c     = KIND_HIT;
    target_way = hit_way;
    wr_en      = 1'b0;
    wr_tag_en  = 1'b0;
    new_vbits  = hit_vbits;
    if (!sb_hit) begin
      kind_c     = KIND_SB_MISS;
      target_way = empty_found ? empty_way : lru_way;
      wr_en      = accept;
      wr_tag_en  = 1'b1;
      new_vbits  = sub_onehot;
    end else if (!sub_valid) begin
      kind_c    = KIND_SUB_MISS;
      wr_en     = accept;
      new_vbits = req_coalloc ? (hit_vbits | sub_onehot) : sub_onehot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid         <= 1'b0;
      rsp_kind          <= KIND_NONE;
      rsp_way           <= '0;
      rsp_victim        <= '0;
      rsp_prefetch_cand <= 1'b0;
    end else begin
      rsp_valid         <= accept;
      rsp_prefetch_cand <= accept && (kind_c == KIND_SUB_MISS);
      if (accept) begin
        rsp_kind   <= kind_c;
        rsp_way    <= target_way;
        rsp_victim <= (kind_c == KIND_SB_MISS) ? target_way : '0;
      end
    end
  end

  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  p_prefetch_kind_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_prefetch_cand |-> (rsp_valid && rsp_kind == KIND_SUB_MISS));
  p_victim_way_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == KIND_SB_MISS) |-> (rsp_way == rsp_victim));
endmodule

// File: tb/tb_sb_lookup.sv
`timescale 1ns/1ps
module tb_sb_lookup;
  localparam int ADDR_W = 32;
  localparam int WAY_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_coalloc = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_kind;
  logic [WAY_W-1:0] rsp_way, rsp_victim;
  logic rsp_prefetch_cand;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sb_lookup dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_coalloc(req_coalloc), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
    .rsp_prefetch_cand(rsp_prefetch_cand)
  );

  // R1 split: tag[31:14], set[13:8], sub[7:6], offset[5:0]
  function automatic logic [31:0] mk(input int tag, input int set, input int sub, input int off);
    return {tag[17:0], set[5:0], sub[1:0], off[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one request and check the registered response one cycle later.
  task automatic access(input logic [31:0] a, input bit co, input int ekind,
                        input int eway, input string req);
    @(negedge clk);
    req_addr = a; req_coalloc = co; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " R2 rsp_valid"}, int'(rsp_valid), 1);
    chk(int'(rsp_kind) == ekind, {req, " kind"}, int'(rsp_kind), ekind);
    chk(int'(rsp_way) == eway, {req, " way"}, int'(rsp_way), eway);
    chk(rsp_prefetch_cand == (ekind == 2), "R5 prefetch flag", int'(rsp_prefetch_cand), int'(ekind == 2));
    chk(int'(rsp_victim) == (ekind == 1 ? eway : 0), "R7 victim", int'(rsp_victim), (ekind == 1 ? eway : 0));
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R2 reset rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle no rsp", int'(rsp_valid), 0);
  endtask

  task automatic t_basic();
    access(mk(5, 0, 0, 0), 1'b0, 1, 0, "R3 first miss");
    access(mk(5, 0, 0, 7), 1'b0, 3, 0, "R6 full hit");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_coalloc();
    access(mk(5, 0, 1, 0), 1'b1, 2, 0, "R4 sub miss");
    access(mk(5, 0, 0, 0), 1'b0, 3, 0, "R8 sibling kept");
    access(mk(5, 0, 1, 0), 1'b0, 3, 0, "R8 new valid");
  endtask

  task automatic t_no_coalloc();
    access(mk(5, 0, 2, 0), 1'b0, 2, 0, "R9 sub miss");
    access(mk(5, 0, 2, 0), 1'b0, 3, 0, "R9 new valid");
    access(mk(5, 0, 0, 0), 1'b1, 2, 0, "R9 sibling dropped");
    access(mk(5, 0, 1, 0), 1'b1, 2, 0, "R9 sibling1 dropped");
  endtask

  task automatic t_fill_lru();
    for (int i = 1; i < 16; i++)
      access(mk(100 + i, 0, 0, 0), 1'b0, 1, i, "R7 empty way fill");
    access(mk(5, 0, 2, 0), 1'b0, 3, 0, "R10 touch way0");
    access(mk(200, 0, 1, 0), 1'b0, 1, 1, "R10 LRU victim way1");
    access(mk(200, 0, 0, 0), 1'b0, 2, 1, "R7 old valid bits cleared");
    access(mk(101, 0, 0, 0), 1'b0, 1, 2, "R10 next LRU way2");
  endtask

  task automatic t_sets_offset();
    access(mk(5, 1, 0, 0), 1'b0, 1, 0, "R11 other set miss");
    access(mk(5, 0, 2, 63), 1'b0, 3, 0, "R11 set0 intact");
    access(mk(5, 0, 3, 21), 1'b0, 2, 0, "R1 sub field bits 7:6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_coalloc();
    t_no_coalloc();
    t_fill_lru();
    t_sets_offset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule